// File: doc/BRIEF.md
# Memory-Driven Maintenance Sequencer

This block steps a processor through a maintenance mode in which 4-bit micro-orders come from main memory rather than from control storage. While the mode-enable input is high, the block repeats a memory cycle made of four phases, W2, R1, R2 and W1, in that order. Each phase lasts `PHASE_CLKS` clocks. In W2 the instruction address advances by one word and a read is issued. In R1 the data register is cleared. In R2 the fetched word, together with its four parity bits, is captured. In W1 those parity bits act as the micro-order.

The latched micro-order is decoded into one of three classes. The first class is a no-operation. The second is a gating order, which is handed to the datapath as a one-clock strobe at the start of the next W2. The third is the order that loads the control-store address register from the data register. That load is followed, at the start of the next W2, by a control-store cycle start strobe. In every other W2 control storage sees a dead cycle. When mode-enable is low, the sequence rests in W2 and issues nothing.

Top module: `mstore_seq`

## Requirements
- R1: The `phase` output steps W2(0) → R1(1) → R2(2) → W1(3) → W2 and stays exactly `PHASE_CLKS` clocks in each phase while mode-enable is high.
- R2: When W2 ends, `mem_addr` advances by `BYTES_PER_WORD` modulo 2^`ADDR_W`, starting from `START_ADDR`. `mem_req` is high for exactly the first clock of R1. The memory returns the addressed word from the clock after the request and holds it until the next request.
- R3: At the end of R1 the data register (`sdr_data`, `sdr_par`) is cleared, so it reads zero throughout R2.
- R4: At the end of R2 the data register captures `mem_rdata` and `mem_rpar`, and it holds them through W1.
- R5: On entry to W1, `op_q` takes the four parity bits of the fetched word, but only if `test_normal` is high at that edge. If it is low, `op_q` keeps its previous value.
- R6: A freshly latched op code 0xA loads `csar` from `sdr_data[CS_W-1:0]` at the end of W1. `cs_start` is then high for the first clock of the next W2. After any other cycle, `cs_start` stays low and `csar` holds its value.
- R7: Freshly latched codes other than 0x0, 0x9, 0xD and 0xA raise `exec_strobe` for the first clock of the next W2, with the code visible on `op_q`. The no-op codes 0x0, 0x9 and 0xD raise neither strobe, and neither does a cycle whose op was not latched.
- R8: While mode-enable is low in W2, the phase stays W2, `mem_req` stays low and `mem_addr` holds its value. A cycle already past W2 runs on to its end.
- R9: Reset leaves phase W2, `mem_addr` = `START_ADDR`, and every other output at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Memory-driven mode enable |
| test_normal | input | 1 | Test selector in normal position; allows op latching |
| mem_req | output | 1 | One-clock read request |
| mem_addr | output | ADDR_W | Instruction/storage address of the request |
| mem_rdata | input | DATA_W | Read data word |
| mem_rpar | input | 4 | Parity bits of the read word |
| phase | output | 2 | Current phase: 0=W2, 1=R1, 2=R2, 3=W1 |
| sdr_data | output | DATA_W | Data register, data part |
| sdr_par | output | 4 | Data register, parity part |
| op_q | output | 4 | Latched micro-order |
| csar | output | CS_W | Control-store address register |
| cs_start | output | 1 | Control-store cycle start strobe |
| exec_strobe | output | 1 | Gating micro-order execute strobe |

## Verification
The bench builds the block with `PHASE_CLKS`=2, an 8-bit address starting at 0xE8, a 16-bit data word and a 6-bit control-store address. Two clocks per phase expose the difference between a phase's first clock and its later clocks. The small address space makes the address wrap past 0xFC within a few cycles. The parity bits of each word are derived from address bits [5:2], so sixteen consecutive fetches sweep every op code, including the control-store load and the three no-ops. The runs also cover idle stretches, a mode drop in the middle of a cycle, and cycles taken with the test selector away from normal.

// File: rtl/ms_pkg.sv
package ms_pkg;

   localparam int PAR_W = 4;

   typedef enum logic [1:0] {
      PH_W2 = 2'd0,
      PH_R1 = 2'd1,
      PH_R2 = 2'd2,
      PH_W1 = 2'd3
   } ms_phase_e;

   localparam logic [PAR_W-1:0] OP_CSAR_LD = 4'hA;

   function automatic logic op_is_noop(input logic [PAR_W-1:0] op);
      return (op == 4'h0) || (op == 4'h9) || (op == 4'hD);
   endfunction

   function automatic logic op_is_gate(input logic [PAR_W-1:0] op);
      return !op_is_noop(op) && (op != OP_CSAR_LD);
   endfunction

endpackage

// File: rtl/ms_phase_seq.sv
module ms_phase_seq #(
   parameter int PHASE_CLKS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_en,
   output ms_pkg::ms_phase_e phase,
   output logic             adv
);
   import ms_pkg::*;

   logic hold;
   logic tick;

   // the sequence rests in W2 while the mode is off
   assign hold = (phase == PH_W2) && !mode_en;
   assign adv  = tick && !hold;

   generate
      if (PHASE_CLKS == 1) begin : g_single
         assign tick = 1'b1;
      end else begin : g_multi
         localparam int CW = $clog2(PHASE_CLKS);
         logic [CW-1:0] cnt;
         assign tick = (cnt == CW'(PHASE_CLKS - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (!hold)
               cnt <= tick ? '0 : cnt + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         phase <= PH_W2;
      else if (adv)
         phase <= ms_phase_e'(phase + 2'd1);
   end

endmodule

// File: rtl/ms_fetch.sv
module ms_fetch #(
   parameter int              ADDR_W     = 16,
   parameter int              DATA_W     = 32,
   parameter logic [ADDR_W-1:0] STEP     = 4,
   parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  ms_pkg::ms_phase_e        phase,
   input  logic                     adv,
   input  logic [DATA_W-1:0]        mem_rdata,
   input  logic [ms_pkg::PAR_W-1:0] mem_rpar,
   output logic                     mem_req,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [DATA_W-1:0]        sdr_data,
   output logic [ms_pkg::PAR_W-1:0] sdr_par
);
   import ms_pkg::*;

   logic w2_done, r1_done, r2_done;

   assign w2_done = adv && (phase == PH_W2);
   assign r1_done = adv && (phase == PH_R1);
   assign r2_done = adv && (phase == PH_R2);

   // instruction address advances one word just before it is requested
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr <= START_ADDR;
         mem_req  <= 1'b0;
      end else begin
         mem_req <= w2_done;
         if (w2_done)
            mem_addr <= mem_addr + STEP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sdr_data <= '0;
         sdr_par  <= '0;
      end else if (r1_done) begin
         sdr_data <= '0;
         sdr_par  <= '0;
      end else if (r2_done) begin
         sdr_data <= mem_rdata;
         sdr_par  <= mem_rpar;
      end
   end

endmodule

// File: rtl/ms_op_ctl.sv
module ms_op_ctl #(
   parameter int CS_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  ms_pkg::ms_phase_e        phase,
   input  logic                     adv,
   input  logic                     test_normal,
   input  logic [ms_pkg::PAR_W-1:0] mem_rpar,
   input  logic [CS_W-1:0]          sdr_low,
   output logic [ms_pkg::PAR_W-1:0] op_q,
   output logic [CS_W-1:0]          csar,
   output logic                     cs_start,
   output logic                     exec_strobe
);
   import ms_pkg::*;

   logic r2_done, w1_done;
   logic fresh;

   assign r2_done = adv && (phase == PH_R2);
   assign w1_done = adv && (phase == PH_W1);

   // the parity bits entering the data register become the op at W1 entry
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q  <= '0;
         fresh <= 1'b0;
      end else if (r2_done) begin
         fresh <= test_normal;
         if (test_normal)
            op_q <= mem_rpar;
      end else if (w1_done) begin
         fresh <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csar        <= '0;
         cs_start    <= 1'b0;
         exec_strobe <= 1'b0;
      end else begin
         cs_start    <= w1_done && fresh && (op_q == OP_CSAR_LD);
         exec_strobe <= w1_done && fresh && op_is_gate(op_q);
         if (w1_done && fresh && (op_q == OP_CSAR_LD))
            csar <= sdr_low;
      end
   end

endmodule

// File: rtl/mstore_seq.sv
module mstore_seq #(
   parameter int              ADDR_W         = 16,
   parameter int              DATA_W         = 32,
   parameter int              CS_W           = 12,
   parameter int              PHASE_CLKS     = 1,
   parameter int              BYTES_PER_WORD = 4,
   parameter logic [ADDR_W-1:0] START_ADDR   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_en,
   input  logic              test_normal,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [3:0]        mem_rpar,
   output logic [1:0]        phase,
   output logic [DATA_W-1:0] sdr_data,
   output logic [3:0]        sdr_par,
   output logic [3:0]        op_q,
   output logic [CS_W-1:0]   csar,
   output logic              cs_start,
   output logic              exec_strobe
);
   import ms_pkg::*;

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BYTES_PER_WORD);

   generate
      if (PHASE_CLKS < 1)
         $error("PHASE_CLKS must be at least 1");
      if (CS_W < 1 || CS_W > DATA_W)
         $error("CS_W must lie within the data word");
      if (BYTES_PER_WORD < 1 || (BYTES_PER_WORD & (BYTES_PER_WORD - 1)) != 0)
         $error("BYTES_PER_WORD must be a power of two");
      if (ADDR_W < 2)
         $error("ADDR_W too small");
   endgenerate

   ms_phase_e ph;
   logic      adv;

   assign phase = ph;

   ms_phase_seq #(.PHASE_CLKS(PHASE_CLKS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_en (mode_en),
      .phase   (ph),
      .adv     (adv)
   );

   ms_fetch #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .STEP       (STEP),
      .START_ADDR (START_ADDR)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (ph),
      .adv       (adv),
      .mem_rdata (mem_rdata),
      .mem_rpar  (mem_rpar),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .sdr_data  (sdr_data),
      .sdr_par   (sdr_par)
   );

   ms_op_ctl #(.CS_W(CS_W)) u_op (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase       (ph),
      .adv         (adv),
      .test_normal (test_normal),
      .mem_rpar    (mem_rpar),
      .sdr_low     (sdr_data[CS_W-1:0]),
      .op_q        (op_q),
      .csar        (csar),
      .cs_start    (cs_start),
      .exec_strobe (exec_strobe)
   );

endmodule

// File: rtl/ms_seq_chk.sv
module ms_seq_chk #(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 32,
   parameter int BYTES_PER_WORD = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_en,
   input logic [1:0]        phase,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] sdr_data,
   input logic [3:0]        sdr_par,
   input logic [3:0]        op_q,
   input logic              cs_start,
   input logic              exec_strobe
);
   import ms_pkg::*;

   a_r1_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (phase == $past(phase)) || (phase == 2'($past(phase) + 2'd1)));

   a_r2_req_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (phase == 2'd1));

   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(BYTES_PER_WORD))));

   a_r3_sdr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'd2 && $past(phase) == 2'd1) |-> (sdr_data == '0 && sdr_par == '0));

   a_r6_cs_start_w2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_start |-> (phase == 2'd0 && $past(phase) == 2'd3));

   a_r7_exec_not_noop: assert property (@(posedge clk) disable iff (!rst_n)
      exec_strobe |-> (!op_is_noop(op_q) && op_q != OP_CSAR_LD));

   a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs_start && exec_strobe));

   a_r8_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_en && phase == 2'd0) |=> (!mem_req && $stable(mem_addr)));

endmodule

bind mstore_seq ms_seq_chk #(
   .ADDR_W         (ADDR_W),
   .DATA_W         (DATA_W),
   .BYTES_PER_WORD (BYTES_PER_WORD)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_en     (mode_en),
   .phase       (phase),
   .mem_req     (mem_req),
   .mem_addr    (mem_addr),
   .sdr_data    (sdr_data),
   .sdr_par     (sdr_par),
   .op_q        (op_q),
   .cs_start    (cs_start),
   .exec_strobe (exec_strobe)
);

// File: tb/tb_mstore_seq.sv
module tb_mstore_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW  = 8;
   localparam int DW  = 16;
   localparam int CW  = 6;
   localparam int P   = 2;
   localparam logic [AW-1:0] S = 8'hE8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_en = 1'b0;
   logic          test_normal = 1'b1;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata = '0;
   logic [3:0]    mem_rpar = '0;
   logic [1:0]    phase;
   logic [DW-1:0] sdr_data;
   logic [3:0]    sdr_par;
   logic [3:0]    op_q;
   logic [CW-1:0] csar;
   logic          cs_start;
   logic          exec_strobe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mstore_seq #(
      .ADDR_W(AW), .DATA_W(DW), .CS_W(CW), .PHASE_CLKS(P),
      .BYTES_PER_WORD(4), .START_ADDR(S)
   ) dut (
      .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .test_normal(test_normal),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_rpar(mem_rpar), .phase(phase), .sdr_data(sdr_data),
      .sdr_par(sdr_par), .op_q(op_q), .csar(csar), .cs_start(cs_start),
      .exec_strobe(exec_strobe)
   );

   function automatic logic [DW-1:0] word_data(input logic [AW-1:0] a);
      return {~a, a};
   endfunction

   function automatic logic [3:0] word_par(input logic [AW-1:0] a);
      return a[5:2] ^ 4'h5;
   endfunction

   function automatic bit is_gate(input logic [3:0] op);
      return !(op == 4'h0 || op == 4'h9 || op == 4'hD || op == 4'hA);
   endfunction

   // memory model: word valid from the clock after the request
   always @(posedge clk) begin
      if (mem_req) begin
         mem_rdata <= word_data(mem_addr);
         mem_rpar  <= word_par(mem_addr);
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // expected state
   logic [AW-1:0] next_addr = S;
   logic [3:0]    exp_op = 4'h0;
   logic [CW-1:0] exp_csar = '0;
   bit            prev_fresh = 1'b0;
   logic [3:0]    prev_op = 4'h0;
   logic [DW-1:0] prev_data = '0;

   task automatic check_strobes();
      bit exp_cs;
      bit exp_ex;
      exp_cs = prev_fresh && (prev_op == 4'hA);
      exp_ex = prev_fresh && is_gate(prev_op);
      if (exp_cs) exp_csar = prev_data[CW-1:0];
      chk(cs_start == exp_cs, "R6 cs_start", 32'(cs_start), 32'(exp_cs));
      chk(csar == exp_csar, "R6 csar", 32'(csar), 32'(exp_csar));
      chk(exec_strobe == exp_ex, "R7 exec_strobe", 32'(exec_strobe), 32'(exp_ex));
      if (exp_ex) chk(op_q == prev_op, "R7 op on exec", 32'(op_q), 32'(prev_op));
   endtask

   // caller is at the negedge inside W2 clock 0
   task automatic run_cycle(input bit drop_mid);
      logic [AW-1:0] a;
      logic [3:0]    new_op;
      bit            tn;
      a      = next_addr + 8'd4;
      tn     = test_normal;
      new_op = tn ? word_par(a) : exp_op;
      for (int c = 0; c < 4*P; c++) begin
         if (c != 0) @(negedge clk);
         chk(phase == 2'(c / P), "R1 phase", 32'(phase), 32'(c / P));
         if (c == 0) check_strobes();
         else begin
            chk(!cs_start, "R6 no cs_start", 32'(cs_start), 0);
            chk(!exec_strobe, "R7 no exec", 32'(exec_strobe), 0);
         end
         chk(mem_req == (c == P), "R2 mem_req", 32'(mem_req), 32'(c == P));
         if (c >= P) chk(mem_addr == a, "R2 mem_addr", 32'(mem_addr), 32'(a));
         else        chk(mem_addr == next_addr, "R2 addr hold", 32'(mem_addr), 32'(next_addr));
         if (c / P == 2)
            chk(sdr_data == '0 && sdr_par == '0, "R3 sdr clear",
                32'({sdr_par, sdr_data}), 0);
         if (c / P == 3) begin
            chk(sdr_data == word_data(a) && sdr_par == word_par(a), "R4 sdr load",
                32'({sdr_par, sdr_data}), 32'({word_par(a), word_data(a)}));
            chk(op_q == new_op, tn ? "R5 op latch" : "R5 op hold",
                32'(op_q), 32'(new_op));
         end
         if (drop_mid && c == P) mode_en = 1'b0;
      end
      next_addr  = a;
      exp_op     = new_op;
      prev_fresh = tn;
      prev_op    = new_op;
      prev_data  = word_data(a);
   endtask

   // mode_en low: rests in W2; raises mode_en at the last negedge
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(phase == 2'd0, "R8 idle phase", 32'(phase), 0);
         chk(!mem_req, "R8 idle req", 32'(mem_req), 0);
         chk(mem_addr == next_addr, "R8 idle addr", 32'(mem_addr), 32'(next_addr));
         chk(op_q == exp_op, "R8 idle op", 32'(op_q), 32'(exp_op));
         if (i == 0) begin
            check_strobes();
            prev_fresh = 1'b0;
         end else begin
            chk(!cs_start && !exec_strobe, "R8 idle strobes",
                32'({cs_start, exec_strobe}), 0);
         end
      end
      mode_en = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(phase == 2'd0, "R9 phase", 32'(phase), 0);
      chk(mem_addr == S, "R9 addr", 32'(mem_addr), 32'(S));
      chk(!mem_req && !cs_start && !exec_strobe, "R9 strobes",
          32'({mem_req, cs_start, exec_strobe}), 0);
      chk(op_q == 0 && csar == 0 && sdr_data == 0 && sdr_par == 0, "R9 regs",
          32'({op_q, csar, sdr_par}), 0);
      rst_n = 1'b1;
      idle(3);
      // sweep all 16 op codes across the address wrap
      for (int k = 0; k < 18; k++) begin
         if (k > 0) @(negedge clk);
         run_cycle(1'b0);
      end
      mode_en = 1'b0;
      idle(5);
      run_cycle(1'b0);
      @(negedge clk);
      run_cycle(1'b0);
      // test selector off the normal position
      @(negedge clk);
      test_normal = 1'b0;
      run_cycle(1'b0);
      @(negedge clk);
      run_cycle(1'b0);
      @(negedge clk);
      test_normal = 1'b1;
      for (int k = 0; k < 3; k++) begin
         run_cycle(1'b0);
         @(negedge clk);
      end
      // mode drop in the middle of a cycle: cycle completes, then rests
      run_cycle(1'b1);
      idle(4);
      for (int k = 0; k < 14; k++) begin
         if (k > 0) @(negedge clk);
         run_cycle(1'b0);
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule